// File: doc/BRIEF.md
# Card Command State Machine with Sleep

This block is the card-side control core of an embedded flash card. A command front end hands it a decoded command index and a 32-bit argument with a one-cycle `cmd_valid` strobe. The block walks the card through its life cycle (idle, ready, identification, standby, transfer, sleep, inactive). For every command it returns a response-type code with a one-cycle `rsp_valid` strobe, so the front end knows whether to send a normal response, a busy-type response, no response at all, or to flag the command as issued in the wrong state.

The block keeps the card's relative address and the multi-block count, and it exposes a 32-bit status word. A sleep state is entered and left through one argument bit of the sleep/awake command. While the card is asleep it ignores all traffic except that command and a reset carrying one of two fixed argument values. Once the card has been placed in the inactive state it answers nothing, and only the hardware reset brings it back. Data transfer, CRC and the contents of the card's identification registers belong to other blocks.

`rst_n` is asynchronous and active low. It must be released synchronously to `clk` by the reset synchroniser in front of this block.

Top module: `card_cmd_fsm`

## Requirements
- R1: After `rst_n` is deasserted, the state is idle (code 0), `rca` is 0x0001, `blk_cnt` is 0, `status` is all zero and `rsp_valid` is low.
- R2: Each command presented with `cmd_valid` high at a rising edge yields `rsp_valid` high for exactly the following cycle. In that cycle `rsp_type` carries 0 for no response, 1 for R1, 2 for busy-type R1b or 3 for invalid-state. State, `rca`, `blk_cnt` and `status` take their new values in that same cycle.
- R3: Command 1 moves idle to ready, and command 2 moves ready to identification. Both answer R1. In any other state each of them answers invalid-state and leaves the state unchanged.
- R4: Command 3 in the identification or standby state copies argument bits 31:16 into `rca`, moves to standby and answers R1. In any other state it answers invalid-state and changes nothing.
- R5: Command 7 in standby moves to transfer when argument bits 31:16 equal `rca`, and otherwise stays in standby. In transfer, a non-matching address moves the card back to standby and a matching one keeps it in transfer. All four cases answer R1. In any other state command 7 is invalid-state.
- R6: Command 5 answers R1b in standby and in sleep. In standby, argument bit 15 set enters sleep (code 9) and bit 15 clear stays in standby. In sleep, bit 15 clear returns to standby and bit 15 set stays in sleep. In any other state it is invalid-state.
- R7: In sleep, every command whose index is neither 0 nor 5 answers no-response (code 0) and changes no state, address, count or status bit. This applies to the application prefix (command 55) as well.
- R8: In sleep, command 0 resets the card only when its argument is 0x00000000 or 0xF0F0F0F0. With any other argument it answers no-response and changes nothing.
- R9: Command 15 moves any state except sleep to inactive (code 15) and answers no-response. In inactive, every command answers no-response and changes nothing, command 0 included.
- R10: Command 0, outside sleep and inactive, returns the card to idle, sets `rca` to 0x0001, clears `blk_cnt` and the illegal-command bit, and answers no-response.
- R11: Command 23 in transfer loads `blk_cnt` with argument bits 15:0 and ignores bits 31:16, answering R1. In any other state it is invalid-state and `blk_cnt` keeps its value.
- R12: `status` bits 12:9 hold the state code and bit 22 is the illegal-command bit. All other bits read 0. Every invalid-state answer sets bit 22. The bit stays set until command 13 (status read) is accepted in standby or transfer, and that command answers R1 and clears the bit. Command 13 in idle, ready or identification is invalid-state.
- R13: Command 55 answers R1 in idle, standby and transfer and invalid-state in ready and identification. Any index not named in these requirements answers invalid-state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_valid | output | 1 | One-cycle strobe per accepted command |
| rsp_type | output | 3 | Response code: 0 none, 1 R1, 2 R1b, 3 invalid-state |
| status | output | 32 | Card status word (state in 12:9, illegal-command in 22) |
| rca | output | 16 | Relative card address |
| blk_cnt | output | 16 | Multi-block count |

## Verification
The state register shows on `status[12:9]` in the cycle after every command, so any wrong transition is visible one cycle after the command that caused it. A state that is wrong but looks similar, such as standby taken for sleep, also shows up at the next command, because that command's response type differs. A missed or stray illegal-command bit shows on `status[22]` in that same cycle. Corruption of the address or count registers appears at once on `rca` and `blk_cnt`, and it also changes the outcome of a later select command. The bench therefore compares every output against its own model on every clock, which pins each divergence to the command that caused it.

// File: rtl/card_cmd_pkg.sv
`timescale 1ns/1ps
package card_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_READY = 4'd1,
    ST_IDENT = 4'd2,
    ST_STBY  = 4'd3,
    ST_TRAN  = 4'd4,
    ST_PRG   = 4'd7,
    ST_SLP   = 4'd9,
    ST_INA   = 4'd15
  } card_state_e;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_R1   = 3'd1,
    RSP_R1B  = 3'd2,
    RSP_INV  = 3'd3
  } rsp_e;

  localparam int STATE_W   = 4;
  localparam int RSP_W     = 3;
  localparam int STATE_LSB = 9;
  localparam int ILL_BIT   = 22;

endpackage

// File: rtl/card_cmd_gate.sv
`timescale 1ns/1ps
// Decides whether a command is silently dropped by the sleep/inactive filter.
module card_cmd_gate
  import card_cmd_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter int          ARG_W    = 32,
  parameter int          WAKE_IDX = 5,
  parameter logic [31:0] MAGIC_A  = 32'h0000_0000,
  parameter logic [31:0] MAGIC_B  = 32'hF0F0_F0F0
) (
  input  card_state_e      state,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             muted
);

  logic is_reset_cmd;
  logic is_wake_cmd;
  logic magic_ok;

  always_comb begin
    is_reset_cmd = (idx == '0);
    is_wake_cmd  = (idx == IDX_W'(WAKE_IDX));
    magic_ok     = (arg == ARG_W'(MAGIC_A)) || (arg == ARG_W'(MAGIC_B));
    muted        = 1'b0;
    if (state == ST_INA) begin
      muted = 1'b1;
    end else if (state == ST_SLP) begin
      if (is_reset_cmd) begin
        muted = !magic_ok;
      end else if (!is_wake_cmd) begin
        muted = 1'b1;
      end
    end
  end

endmodule

// File: rtl/card_cmd_decode.sv
`timescale 1ns/1ps
// Next-state and response decision for a command that passed the gate.
module card_cmd_decode
  import card_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int RCA_W = 16
) (
  input  card_state_e      state,
  input  logic [IDX_W-1:0] idx,
  input  logic [RCA_W-1:0] arg_addr,
  input  logic             arg_sleep,
  input  logic [RCA_W-1:0] rca,
  output card_state_e      nxt_state,
  output rsp_e             rsp,
  output logic             ld_rca,
  output logic             ld_cnt,
  output logic             soft_rst,
  output logic             stat_rd
);

  logic addr_hit;

  always_comb begin
    addr_hit  = (arg_addr == rca);
    nxt_state = state;
    rsp       = RSP_INV;
    ld_rca    = 1'b0;
    ld_cnt    = 1'b0;
    soft_rst  = 1'b0;
    stat_rd   = 1'b0;
    unique case (idx)
      IDX_W'(0): begin
        nxt_state = ST_IDLE;
        rsp       = RSP_NONE;
        soft_rst  = 1'b1;
      end
      IDX_W'(1): begin
        if (state == ST_IDLE) begin
          nxt_state = ST_READY;
          rsp       = RSP_R1;
        end
      end
      IDX_W'(2): begin
        if (state == ST_READY) begin
          nxt_state = ST_IDENT;
          rsp       = RSP_R1;
        end
      end
      IDX_W'(3): begin
        if (state == ST_IDENT || state == ST_STBY) begin
          nxt_state = ST_STBY;
          rsp       = RSP_R1;
          ld_rca    = 1'b1;
        end
      end
      IDX_W'(5): begin
        if (state == ST_STBY) begin
          rsp = RSP_R1B;
          if (arg_sleep) nxt_state = ST_SLP;
        end else if (state == ST_SLP) begin
          rsp = RSP_R1B;
          if (!arg_sleep) nxt_state = ST_STBY;
        end
      end
      IDX_W'(7): begin
        if (state == ST_STBY) begin
          rsp = RSP_R1;
          if (addr_hit) nxt_state = ST_TRAN;
        end else if (state == ST_TRAN) begin
          rsp = RSP_R1;
          if (!addr_hit) nxt_state = ST_STBY;
        end
      end
      IDX_W'(13): begin
        if (state == ST_STBY || state == ST_TRAN) begin
          rsp     = RSP_R1;
          stat_rd = 1'b1;
        end
      end
      IDX_W'(15): begin
        nxt_state = ST_INA;
        rsp       = RSP_NONE;
      end
      IDX_W'(23): begin
        if (state == ST_TRAN) begin
          rsp    = RSP_R1;
          ld_cnt = 1'b1;
        end
      end
      IDX_W'(55): begin
        if (state == ST_IDLE || state == ST_STBY || state == ST_TRAN) begin
          rsp = RSP_R1;
        end
      end
      default: begin
        rsp = RSP_INV;
      end
    endcase
  end

endmodule

// File: rtl/card_cmd_status.sv
`timescale 1ns/1ps
// Illegal-command flag and status word assembly.
module card_cmd_status
  import card_cmd_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              set_ill,
  input  logic              clr_ill,
  input  logic              soft_rst,
  input  card_state_e       state,
  output logic [STAT_W-1:0] status
);

  logic ill_q;
  logic ill_d;

  always_comb begin
    ill_d = ill_q;
    if (en) begin
      if (soft_rst || clr_ill) ill_d = 1'b0;
      else if (set_ill)        ill_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= ill_d;
  end

  always_comb begin
    status                        = '0;
    status[STATE_LSB +: STATE_W]  = state;
    status[ILL_BIT]               = ill_q;
  end

endmodule

// File: rtl/card_cmd_fsm.sv
`timescale 1ns/1ps
module card_cmd_fsm
  import card_cmd_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter int          ARG_W     = 32,
  parameter int          RCA_W     = 16,
  parameter int          CNT_W     = 16,
  parameter int          STAT_W    = 32,
  parameter int          SLEEP_BIT = 15,
  parameter logic [15:0] RCA_RESET = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_type,
  output logic [STAT_W-1:0] status,
  output logic [RCA_W-1:0]  rca,
  output logic [CNT_W-1:0]  blk_cnt
);

  localparam int ADDR_LSB = ARG_W - RCA_W;

  card_state_e      state_q, state_d;
  logic [RCA_W-1:0] rca_q, rca_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rv_q;
  rsp_e             rt_q, rt_d;

  logic             muted;
  card_state_e      dec_state;
  rsp_e             dec_rsp;
  logic             ld_rca, ld_cnt, soft_rst, stat_rd;
  logic             take;

  card_cmd_gate #(.IDX_W(IDX_W), .ARG_W(ARG_W)) i_gate (
    .state (state_q),
    .idx   (cmd_idx),
    .arg   (cmd_arg),
    .muted (muted)
  );

  card_cmd_decode #(.IDX_W(IDX_W), .RCA_W(RCA_W)) i_decode (
    .state     (state_q),
    .idx       (cmd_idx),
    .arg_addr  (cmd_arg[ARG_W-1 -: RCA_W]),
    .arg_sleep (cmd_arg[SLEEP_BIT]),
    .rca       (rca_q),
    .nxt_state (dec_state),
    .rsp       (dec_rsp),
    .ld_rca    (ld_rca),
    .ld_cnt    (ld_cnt),
    .soft_rst  (soft_rst),
    .stat_rd   (stat_rd)
  );

  assign take = cmd_valid && !muted;

  card_cmd_status #(.STAT_W(STAT_W)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (take),
    .set_ill  (dec_rsp == RSP_INV),
    .clr_ill  (stat_rd),
    .soft_rst (soft_rst),
    .state    (state_q),
    .status   (status)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    rca_d   = rca_q;
    cnt_d   = cnt_q;
    rt_d    = rt_q;
    if (cmd_valid) begin
      rt_d = muted ? RSP_NONE : dec_rsp;
    end
    if (take) begin
      state_d = dec_state;
      if (soft_rst) begin
        rca_d = RCA_RESET[RCA_W-1:0];
        cnt_d = '0;
      end
      if (ld_rca) rca_d = cmd_arg[ADDR_LSB +: RCA_W];
      if (ld_cnt) cnt_d = cmd_arg[CNT_W-1:0];
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rca_q   <= RCA_RESET[RCA_W-1:0];
      cnt_q   <= '0;
      rv_q    <= 1'b0;
      rt_q    <= RSP_NONE;
    end else begin
      state_q <= state_d;
      rca_q   <= rca_d;
      cnt_q   <= cnt_d;
      rv_q    <= cmd_valid;
      rt_q    <= rt_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_type  = rt_q;
  assign rca       = rca_q;
  assign blk_cnt   = cnt_q;

  // R2: a response strobe only follows a command
  a_r2_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  // R7: sleeping card drops everything except reset and sleep/awake
  a_r7_sleep_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && state_q == ST_SLP && cmd_idx != IDX_W'(0) && cmd_idx != IDX_W'(5))
    |=> (state_q == ST_SLP && rsp_type == RSP_NONE && $stable(rca_q) && $stable(status)));

  // R9: inactive card stays inactive and silent
  a_r9_inactive_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && state_q == ST_INA) |=> (state_q == ST_INA && rsp_type == RSP_NONE));

  // R4: address assignment stores the upper argument half
  a_r4_rca_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == IDX_W'(3) && (state_q == ST_IDENT || state_q == ST_STBY))
    |=> (rca == $past(cmd_arg[ADDR_LSB +: RCA_W]) && state_q == ST_STBY));

  // R11: block count keeps only the low half
  a_r11_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == IDX_W'(23) && state_q == ST_TRAN)
    |=> (blk_cnt == $past(cmd_arg[CNT_W-1:0])));

  // R12: an invalid-state answer is always accompanied by the illegal flag
  a_r12_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type == RSP_INV) |-> status[ILL_BIT]);

endmodule

// File: tb/test_card_cmd_fsm.sv
`timescale 1ns/1ps
module test_card_cmd_fsm;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic        rsp_valid;
  logic [2:0]  rsp_type;
  logic [31:0] status;
  logic [15:0] rca;
  logic [15:0] blk_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference model
  int m_state, m_rca, m_cnt, m_ill, m_rv, m_rt;

  card_cmd_fsm i_card_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
    .status(status), .rca(rca), .blk_cnt(blk_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic m_reset();
    m_state = 0; m_rca = 1; m_cnt = 0; m_ill = 0; m_rv = 0; m_rt = 0;
  endtask

  task automatic m_cmd(input int idx, input logic [31:0] arg);
    int hi;
    bit mute;
    hi = int'(arg[31:16]);
    m_rv = 1;
    mute = (m_state == 15) ||
           (m_state == 9 && idx != 5 && !(idx == 0 && (arg == 32'h0 || arg == 32'hF0F0F0F0)));
    if (mute) begin
      m_rt = 0;
      return;
    end
    m_rt = 3;
    if (idx == 0) begin
      m_state = 0; m_rca = 1; m_cnt = 0; m_ill = 0; m_rt = 0;
    end else if (idx == 1 && m_state == 0) begin
      m_state = 1; m_rt = 1;
    end else if (idx == 2 && m_state == 1) begin
      m_state = 2; m_rt = 1;
    end else if (idx == 3 && (m_state == 2 || m_state == 3)) begin
      m_state = 3; m_rca = hi; m_rt = 1;
    end else if (idx == 5 && m_state == 3) begin
      m_rt = 2; if (arg[15]) m_state = 9;
    end else if (idx == 5 && m_state == 9) begin
      m_rt = 2; if (!arg[15]) m_state = 3;
    end else if (idx == 7 && m_state == 3) begin
      m_rt = 1; if (hi == m_rca) m_state = 4;
    end else if (idx == 7 && m_state == 4) begin
      m_rt = 1; if (hi != m_rca) m_state = 3;
    end else if (idx == 13 && (m_state == 3 || m_state == 4)) begin
      m_rt = 1; m_ill = 0;
    end else if (idx == 15) begin
      m_state = 15; m_rt = 0;
    end else if (idx == 23 && m_state == 4) begin
      m_cnt = int'(arg[15:0]); m_rt = 1;
    end else if (idx == 55 && (m_state == 0 || m_state == 3 || m_state == 4)) begin
      m_rt = 1;
    end
    if (m_rt == 3) m_ill = 1;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] exp_status;
    exp_status = '0;
    exp_status[12:9] = 4'(m_state);
    exp_status[22]   = 1'(m_ill);
    chk(tag, "rsp_valid", int'(rsp_valid), m_rv);
    if (m_rv != 0) chk(tag, "rsp_type", int'(rsp_type), m_rt);
    chk(tag, "state", int'(status[12:9]), m_state);
    chk(tag, "status", int'(status), int'(exp_status));
    chk(tag, "rca", int'(rca), m_rca);
    chk(tag, "blk_cnt", int'(blk_cnt), m_cnt);
  endtask

  // one clock: drive at negedge, model at posedge, compare a quarter period later
  task automatic tick(input string tag, input bit v, input int idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = v;
    cmd_idx   = 6'(idx);
    cmd_arg   = arg;
    @(posedge clk);
    if (v) m_cmd(idx, arg);
    else   m_rv = 0;
    #5;
    compare(tag);
  endtask

  task automatic cmd(input string tag, input int idx, input logic [31:0] arg);
    tick(tag, 1'b1, idx, arg);
    tick(tag, 1'b0, 0, 32'h0);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_idx = '0; cmd_arg = '0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #5;
    compare("R1");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_idx = '0; cmd_arg = '0;
    m_reset();
    hw_reset();
    tick("R1", 1'b0, 0, 32'h0);

    // wrong-state commands in idle
    cmd("R3", 2, 32'h0);
    cmd("R12", 13, 32'h0);
    cmd("R13", 55, 32'h0);
    cmd("R13", 9, 32'h0);
    // identification
    cmd("R3", 1, 32'h0);
    cmd("R13", 55, 32'h0);
    cmd("R3", 1, 32'h0);
    cmd("R3", 2, 32'h0);
    cmd("R4", 3, 32'h1234_0000);
    cmd("R4", 3, 32'hBEEF_00FF);
    cmd("R12", 13, 32'h0);
    // selection
    cmd("R5", 7, 32'h1111_0000);
    cmd("R5", 7, 32'hBEEF_0000);
    cmd("R11", 23, 32'hABCD_5678);
    cmd("R4", 3, 32'h4444_0000);
    cmd("R6", 5, 32'h0000_8000);
    cmd("R5", 7, 32'hBEEF_0000);
    cmd("R5", 7, 32'h0000_0000);
    cmd("R11", 23, 32'h0000_9999);
    // sleep entry, filter, awake
    cmd("R6", 5, 32'h0000_0000);
    cmd("R6", 5, 32'h0000_8000);
    cmd("R7", 13, 32'h0);
    cmd("R7", 55, 32'h0);
    cmd("R7", 7, 32'hBEEF_0000);
    cmd("R7", 3, 32'h7777_0000);
    cmd("R7", 23, 32'h0000_0001);
    cmd("R7", 15, 32'h0);
    cmd("R6", 5, 32'hFFFF_FFFF);
    cmd("R8", 0, 32'h0000_0001);
    cmd("R8", 0, 32'hF0F0_F0F1);
    cmd("R6", 5, 32'h0000_0000);
    // back-to-back commands without idle gap
    tick("R2", 1'b1, 5, 32'h0000_8000);
    tick("R2", 1'b1, 13, 32'h0);
    tick("R8", 1'b1, 0, 32'hF0F0_F0F0);
    tick("R2", 1'b0, 0, 32'h0);
    // reset from transfer with a loaded count, via sleep and zero argument
    cmd("R3", 1, 32'h0);
    cmd("R3", 2, 32'h0);
    cmd("R4", 3, 32'h00A5_0000);
    cmd("R5", 7, 32'h00A5_0000);
    cmd("R11", 23, 32'hFFFF_FFFF);
    cmd("R12", 9, 32'h0);
    cmd("R5", 7, 32'h0);
    cmd("R6", 5, 32'h0000_8000);
    cmd("R8", 0, 32'h0000_0000);
    // reset from ready and from identification
    cmd("R3", 1, 32'h0);
    cmd("R10", 0, 32'h1234_5678);
    cmd("R3", 1, 32'h0);
    cmd("R3", 2, 32'h0);
    cmd("R12", 5, 32'h0);
    cmd("R10", 0, 32'hDEAD_BEEF);
    // inactive
    cmd("R3", 1, 32'h0);
    cmd("R9", 15, 32'h0);
    cmd("R9", 0, 32'h0);
    cmd("R9", 1, 32'h0);
    cmd("R9", 5, 32'h0);
    repeat (3) tick("R9", 1'b0, 0, 32'h0);
    hw_reset();
    cmd("R1", 55, 32'h0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule